// File: doc/BRIEF.md
# Serial Audio Link Output Frame Packer

This block produces the outgoing stream of a 13-slot serial codec link running at 256 bit clocks per frame. Every frame opens with a 16-bit tag slot and continues with twelve 20-bit slots. Slot 1 and slot 2 carry a codec register command. Slots 3, 4 and 6 to 11 carry PCM channel samples up to 20 bits wide. Slot 5 carries a 16-bit modem line sample, and slot 12 carries a 16-bit general-purpose I/O word taken straight from a host register. The block drives a frame sync that stays high for the length of the tag slot and shifts the frame out most significant bit first, one bit per clock.

Sample sources are first-word-fall-through FIFOs. The block reads each one through a data bus, an empty flag and a one-cycle pop strobe. When variable-rate output is enabled, the codec's slot-request bits choose which data slots get a sample in the coming frame. A requested slot whose FIFO is empty goes out as zero with its tag bit clear, and a per-slot underrun flag records the miss. Every frame decision is made in the first cycle that sync is high, and the resulting frame is shifted out from the next cycle.

Top module: `slink_frame_packer`

## Requirements
- R1: A frame lasts 256 clocks. `sync` is high for exactly 16 consecutive clocks of each frame. `sdo` carries frame bit 255 (tag bit 15) in the clock after `sync` rises, and then the lower bits one per clock, most significant first.
- R2: Tag bits 14 down to 3 flag slots 1 to 12 as valid, where tag bit (15-s) belongs to slot s. Tag bit 15 is the OR of those twelve flags. Tag bits 2..0 are zero. Slot s occupies frame bits [239-20(s-1) -: 20].
- R3: When `cmd_valid` is high at frame start, slot 1 is {cmd_rd, cmd_idx[6:0], 12'b0} and is flagged valid. For a write (`cmd_rd`=0), slot 2 is {cmd_wdata, 4'b0} and is flagged valid. For a read, slot 2 is zero and invalid. `cmd_taken` pulses. Without a command, slots 1 and 2 are zero and invalid.
- R4: PCM channel c (packed at `pcm_data[20c +: 20]`, c=0..7) is carried in slot c+3 for c<2 and in slot c+4 otherwise. With `pcm_fmt20`=1 the 20-bit value is sent unchanged.
- R5: With `pcm_fmt20`=0, each PCM slot carries the channel's low 16 bits left-justified, with its low 4 bits zero.
- R6: Slot 5 carries {mdm_data, 4'b0}.
- R7: With `gpio_en`=1, slot 12 is {gpio_val, 4'b0} and is flagged valid. Otherwise slot 12 is zero and invalid.
- R8: Data slot index k=0..8 denotes slot k+3. With `vra_en`=1, slot k is filled only when `slot_req[k]`=1. An unrequested slot is zero and invalid, is not popped, and raises no underrun. With `vra_en`=0 all nine slots count as requested.
- R9: A requested data slot whose FIFO is empty goes out as zero and invalid, and no pop is issued for it. Bit k of `underrun` is then set and stays set until reset.
- R10: `pcm_pop`, `mdm_pop` and `cmd_taken` are high only in the clock in which `sync` first becomes high, and only for slots that are filled in that frame.
- R11: In reset, `sync`, `sdo`, every pop strobe, `cmd_taken` and `underrun` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vra_en | input | 1 | Variable-rate mode: fill only requested slots |
| slot_req | input | 9 | Codec slot requests, bit k for slot k+3 |
| pcm_fmt20 | input | 1 | 1: 20-bit PCM samples, 0: 16-bit left-justified |
| pcm_data | input | 160 | Head words of the eight PCM FIFOs, 20 bits each |
| pcm_empty | input | 8 | PCM FIFO empty flags |
| pcm_pop | output | 8 | PCM FIFO pop strobes |
| mdm_data | input | 16 | Head word of the modem FIFO |
| mdm_empty | input | 1 | Modem FIFO empty flag |
| mdm_pop | output | 1 | Modem FIFO pop strobe |
| cmd_valid | input | 1 | Register command pending |
| cmd_rd | input | 1 | Command is a read |
| cmd_idx | input | 7 | Codec register index |
| cmd_wdata | input | 16 | Write data |
| cmd_taken | output | 1 | Command placed in the frame |
| gpio_en | input | 1 | Send the I/O word in slot 12 |
| gpio_val | input | 16 | I/O word for slot 12 |
| sync | output | 1 | Frame sync |
| sdo | output | 1 | Serial data out |
| underrun | output | 9 | Sticky underrun flags, bit k for slot k+3 |

## Verification
The assertions assume the FIFO head words and empty flags are valid and stable in the first cycle of each frame, and that a FIFO never reports data it does not hold. The bench changes every input only on the falling edge at which `sync` has just risen. Inputs then stay constant for the whole frame, so the sampling edge always sees settled values. The sweep steps `vra_en`, the request mask, the empty masks, the sample format, the command kind and the I/O enable through arithmetic sequences. This puts filled, unrequested and underrun slots together in the same frame.

// File: rtl/slink_pkg.sv
package slink_pkg;
    localparam int SLOT_W    = 20;
    localparam int TAG_W     = 16;
    localparam int NUM_SLOTS = 12;
    localparam int FRAME_W   = TAG_W + NUM_SLOTS * SLOT_W;
    localparam int CNT_W     = $clog2(FRAME_W);
    localparam int NUM_DATA  = 9;   // slots 3..11
    localparam int MODEM_IDX = 2;   // data index of slot 5
    localparam int PCM_CH    = NUM_DATA - 1;
    localparam int SMP16_W   = 16;
    localparam int PAD_W     = SLOT_W - SMP16_W;
    localparam int IDX_W     = 7;

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic               sync;
        logic               sdo;
        logic [FRAME_W-1:0] sh;
    } ser_state_t;
endpackage

// File: rtl/slot_select.sv
module slot_select
    import slink_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                vra_en,
    input  logic [NUM_DATA-1:0] slot_req,
    input  logic [NUM_DATA-1:0] fifo_empty,
    output logic [NUM_DATA-1:0] fill,
    output logic [NUM_DATA-1:0] pop,
    output logic [NUM_DATA-1:0] urun
);
    logic [NUM_DATA-1:0] want;
    logic [NUM_DATA-1:0] urun_d, urun_q;

    for (genvar k = 0; k < NUM_DATA; k++) begin : g_slot
        always_comb begin
            want[k] = !vra_en || slot_req[k];
            fill[k] = want[k] && !fifo_empty[k];
            pop[k]  = fill[k] && frame_start;
        end
    end

    always_comb begin
        urun_d = urun_q;
        if (frame_start) begin
            urun_d = urun_q | (want & fifo_empty);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) urun_q <= '0;
        else        urun_q <= urun_d;
    end

    assign urun = urun_q;

    assert_urun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        &(~$past(urun_q) | urun_q));

    assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop & fifo_empty) == '0);
endmodule

// File: rtl/frame_assemble.sv
module frame_assemble
    import slink_pkg::*;
(
    input  logic                             cmd_valid,
    input  logic                             cmd_rd,
    input  logic [IDX_W-1:0]                 cmd_idx,
    input  logic [SMP16_W-1:0]               cmd_wdata,
    input  logic [NUM_DATA-1:0]              fill,
    input  logic [NUM_DATA-1:0][SLOT_W-1:0]  data_word,
    input  logic                             gpio_en,
    input  logic [SMP16_W-1:0]               gpio_val,
    output logic [FRAME_W-1:0]               frame
);
    localparam int BODY_TOP = FRAME_W - TAG_W - 1;

    logic [NUM_SLOTS-1:0][SLOT_W-1:0] word;
    logic [NUM_SLOTS-1:0]             vld;
    logic [TAG_W-1:0]                 tag;

    always_comb begin
        word[0] = cmd_valid ? {cmd_rd, cmd_idx, {(SLOT_W-IDX_W-1){1'b0}}} : '0;
        vld[0]  = cmd_valid;
        word[1] = (cmd_valid && !cmd_rd) ? {cmd_wdata, {PAD_W{1'b0}}} : '0;
        vld[1]  = cmd_valid && !cmd_rd;
        for (int k = 0; k < NUM_DATA; k++) begin
            word[k+2] = fill[k] ? data_word[k] : '0;
            vld[k+2]  = fill[k];
        end
        word[NUM_SLOTS-1] = gpio_en ? {gpio_val, {PAD_W{1'b0}}} : '0;
        vld[NUM_SLOTS-1]  = gpio_en;

        tag = '0;
        tag[TAG_W-1] = |vld;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            tag[TAG_W-2-s] = vld[s];
        end

        frame = '0;
        frame[FRAME_W-1 -: TAG_W] = tag;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            frame[BODY_TOP - s*SLOT_W -: SLOT_W] = word[s];
        end
    end
endmodule

// File: rtl/slink_frame_packer.sv
module slink_frame_packer
    import slink_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      vra_en,
    input  logic [NUM_DATA-1:0]       slot_req,
    input  logic                      pcm_fmt20,
    input  logic [PCM_CH*SLOT_W-1:0]  pcm_data,
    input  logic [PCM_CH-1:0]         pcm_empty,
    output logic [PCM_CH-1:0]         pcm_pop,
    input  logic [SMP16_W-1:0]        mdm_data,
    input  logic                      mdm_empty,
    output logic                      mdm_pop,
    input  logic                      cmd_valid,
    input  logic                      cmd_rd,
    input  logic [IDX_W-1:0]          cmd_idx,
    input  logic [SMP16_W-1:0]        cmd_wdata,
    output logic                      cmd_taken,
    input  logic                      gpio_en,
    input  logic [SMP16_W-1:0]        gpio_val,
    output logic                      sync,
    output logic                      sdo,
    output logic [NUM_DATA-1:0]       underrun
);
    ser_state_t state_d, state_q;

    logic                            frame_start;
    logic [NUM_DATA-1:0]             emp_all, fill, pop_all;
    logic [NUM_DATA-1:0][SLOT_W-1:0] data_word;
    logic [FRAME_W-1:0]              frame;
    logic [CNT_W-1:0]                cnt_nxt;

    assign frame_start = (state_q.cnt == '0);

    // map the data-slot index onto the PCM channels and the modem FIFO
    for (genvar k = 0; k < NUM_DATA; k++) begin : g_map
        if (k == MODEM_IDX) begin : g_mdm
            assign data_word[k] = {mdm_data, {PAD_W{1'b0}}};
            assign emp_all[k]   = mdm_empty;
            assign mdm_pop      = pop_all[k];
        end else begin : g_pcm
            localparam int CH = (k < MODEM_IDX) ? k : k - 1;
            assign data_word[k] = pcm_fmt20 ? pcm_data[CH*SLOT_W +: SLOT_W]
                                            : {pcm_data[CH*SLOT_W +: SMP16_W], {PAD_W{1'b0}}};
            assign emp_all[k]   = pcm_empty[CH];
            assign pcm_pop[CH]  = pop_all[k];
        end
    end

    slot_select u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .vra_en      (vra_en),
        .slot_req    (slot_req),
        .fifo_empty  (emp_all),
        .fill        (fill),
        .pop         (pop_all),
        .urun        (underrun)
    );

    frame_assemble u_asm (
        .cmd_valid (cmd_valid),
        .cmd_rd    (cmd_rd),
        .cmd_idx   (cmd_idx),
        .cmd_wdata (cmd_wdata),
        .fill      (fill),
        .data_word (data_word),
        .gpio_en   (gpio_en),
        .gpio_val  (gpio_val),
        .frame     (frame)
    );

    assign cmd_taken = frame_start && cmd_valid;

    always_comb begin
        cnt_nxt = (state_q.cnt == CNT_W'(FRAME_W-1)) ? '0 : state_q.cnt + 1'b1;
        state_d      = state_q;
        state_d.cnt  = cnt_nxt;
        state_d.sync = (32'(cnt_nxt) < TAG_W);
        if (frame_start) begin
            state_d.sdo = frame[FRAME_W-1];
            state_d.sh  = frame << 1;
        end else begin
            state_d.sdo = state_q.sh[FRAME_W-1];
            state_d.sh  = state_q.sh << 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.cnt  <= CNT_W'(FRAME_W-1);
            state_q.sync <= 1'b0;
            state_q.sdo  <= 1'b0;
            state_q.sh   <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sync = state_q.sync;
    assign sdo  = state_q.sdo;

    assert_sync_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q.sync) |-> (32'(state_q.cnt) == TAG_W));

    assert_first_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.sync) |=> (state_q.sdo == $past(frame[FRAME_W-1])));

    assert_pop_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|pcm_pop) || mdm_pop || cmd_taken) |-> $rose(state_q.sync));

    assert_vra_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vra_en |-> ((pop_all & ~slot_req) == '0));
endmodule

// File: tb/tb_slink_frame_packer.sv
module tb_slink_frame_packer;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vra_en = 1'b0;
    logic [8:0]   slot_req = '0;
    logic         pcm_fmt20 = 1'b1;
    logic [159:0] pcm_data = '0;
    logic [7:0]   pcm_empty = '0;
    logic [7:0]   pcm_pop;
    logic [15:0]  mdm_data = '0;
    logic         mdm_empty = 1'b0;
    logic         mdm_pop;
    logic         cmd_valid = 1'b0;
    logic         cmd_rd = 1'b0;
    logic [6:0]   cmd_idx = '0;
    logic [15:0]  cmd_wdata = '0;
    logic         cmd_taken;
    logic         gpio_en = 1'b0;
    logic [15:0]  gpio_val = '0;
    logic         sync, sdo;
    logic [8:0]   underrun;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;

    always #(CLK_P/2) clk = ~clk;

    slink_frame_packer dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    logic [8:0]   exp_urun = '0;

    task automatic run_frame();
        logic [8:0]   want, emp, fill;
        logic [7:0]   e_pcm;
        logic [19:0]  w [12];
        logic [11:0]  v;
        logic [15:0]  tag;
        logic [255:0] got;
        int           ch;
        string        tagname;
        for (int k = 0; k < 9; k++) begin
            ch     = (k < 2) ? k : k - 1;
            want[k] = !vra_en || slot_req[k];
            emp[k]  = (k == 2) ? mdm_empty : pcm_empty[ch];
            fill[k] = want[k] && !emp[k];
        end
        for (int c = 0; c < 8; c++) e_pcm[c] = fill[(c < 2) ? c : c + 1];
        w[0] = cmd_valid ? {cmd_rd, cmd_idx, 12'h000} : 20'h0;
        v[0] = cmd_valid;
        w[1] = (cmd_valid && !cmd_rd) ? {cmd_wdata, 4'h0} : 20'h0;
        v[1] = cmd_valid && !cmd_rd;
        for (int k = 0; k < 9; k++) begin
            ch = (k < 2) ? k : k - 1;
            if (!fill[k])        w[k+2] = 20'h0;
            else if (k == 2)     w[k+2] = {mdm_data, 4'h0};
            else if (pcm_fmt20)  w[k+2] = pcm_data[ch*20 +: 20];
            else                 w[k+2] = {pcm_data[ch*20 +: 16], 4'h0};
            v[k+2] = fill[k];
        end
        w[11] = gpio_en ? {gpio_val, 4'h0} : 20'h0;
        v[11] = gpio_en;
        tag = {|v, v[0], v[1], v[2], v[3], v[4], v[5], v[6], v[7], v[8], v[9], v[10], v[11], 3'b000};
        exp_urun = exp_urun | (want & emp);

        #1;
        chk(pcm_pop == e_pcm, "R10 pcm_pop at frame start", 32'(pcm_pop), 32'(e_pcm));
        chk(mdm_pop == fill[2], "R6 mdm_pop at frame start", 32'(mdm_pop), 32'(fill[2]));
        chk(cmd_taken == cmd_valid, "R3 cmd_taken", 32'(cmd_taken), 32'(cmd_valid));

        for (int j = 0; j < 256; j++) begin
            @(negedge clk);
            got[255-j] = sdo;
            if (sync != ((j < 15) || (j == 255)))
                chk(1'b0, "R1 sync shape", 32'(sync), 32'(j));
            if (j == 0) begin
                chk((pcm_pop == 0) && !mdm_pop && !cmd_taken, "R10 strobes one cycle",
                    {pcm_pop, mdm_pop, cmd_taken}, 32'h0);
                chk(underrun == exp_urun, "R9 underrun sticky", 32'(underrun), 32'(exp_urun));
            end
        end
        chk(1'b1, "R1 sync shape", 32'h0, 32'h0);
        chk(got[255:240] == tag, "R2 tag", 32'(got[255:240]), 32'(tag));
        for (int s = 0; s < 12; s++) begin
            if (s < 2)            tagname = "R3 command slot";
            else if (s == 11)     tagname = "R7 gpio slot";
            else if (!want[s-2])  tagname = "R8 unrequested slot";
            else if (!fill[s-2])  tagname = "R9 underrun slot";
            else if (s == 4)      tagname = "R6 modem slot";
            else if (pcm_fmt20)   tagname = "R4 pcm20 slot";
            else                  tagname = "R5 pcm16 slot";
            chk(got[239 - 20*s -: 20] == w[s], tagname, 32'(got[239 - 20*s -: 20]), 32'(w[s]));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!sync && !sdo, "R11 reset sync/sdo", {sync, sdo}, 32'h0);
        chk(underrun == 0 && pcm_pop == 0 && !mdm_pop && !cmd_taken, "R11 reset strobes",
            {underrun, pcm_pop, mdm_pop, cmd_taken}, 32'h0);
        rst_n = 1'b1;
        while (!sync) @(negedge clk);
        for (int i = 0; i < 48; i++) begin
            vra_en    = (i % 3) != 0;
            slot_req  = 9'((i * 37 + 5) & 9'h1ff);
            pcm_fmt20 = i[1];
            for (int c = 0; c < 8; c++)
                pcm_data[c*20 +: 20] = 20'((i * 7919 + c * 40503 + 1) & 20'hfffff);
            pcm_empty = (i % 5 == 4) ? 8'((i * 11) & 8'hff) : 8'h00;
            mdm_data  = 16'(i * 1021 + 7);
            mdm_empty = (i % 7) == 6;
            cmd_valid = (i % 4) != 3;
            cmd_rd    = i[2];
            cmd_idx   = 7'(i * 3);
            cmd_wdata = 16'(16'hA000 + i * 257);
            gpio_en   = (i % 2) == 0;
            gpio_val  = 16'(16'h1234 ^ (i * 4099));
            run_frame();
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule